// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial bus, fronting a 2048-byte memory held in a register array inside the block. A fast system clock samples the bus clock and data lines. The block recognises bus start and stop events and decodes a device byte that carries the three top memory address bits. It then takes a word address byte and serves writes and reads. Acknowledge and read data leave the block as an active-high pull-down enable for an open-drain data pad.

Writes collect into a page buffer of 16 bytes. Each byte that arrives is marked valid, and the marked bytes are committed to the array in one step when the stop event comes. After that step the block stays deaf to its own device byte for a programmable number of system clocks, so a host can poll until the write has finished. A write-protect input refuses the first data byte with a negative acknowledge. A reset-hold input blocks every device-byte acknowledge. Reads return bytes from an 11-bit pointer. The pointer keeps its value between transactions, advances across the whole array and wraps to zero.

Top module: `i2c_mem_slave`

## Requirements
- R1: A device byte is acknowledged only when its upper nibble is binary 1010 (bits 7..4). Bits 3..1 carry memory address bits 10..8, and bit 0 selects the direction (1 = read, 0 = write). Any other nibble gets no acknowledge.
- R2: In a write, the byte after the device byte is taken as address bits 7..0 and is acknowledged. Each data byte is acknowledged, and the data can be read back once the stop event has been seen.
- R3: Within one write, the data address advances only in its low four bits. A byte after the sixteenth wraps inside the 16-byte page and replaces the byte written earlier there. Only bytes actually received are programmed; other bytes of the page keep their old contents.
- R4: After a stop that ends a write with at least one accepted data byte, no device byte is acknowledged for BUSY_CYCLES system clocks. After that interval, device bytes are acknowledged again.
- R5: With write-protect high, the device byte and the word address are acknowledged, the first data byte is not acknowledged, and the memory is left unchanged.
- R6: A read that follows the device byte directly returns the byte at the pointer. The pointer holds one past the last byte accessed.
- R7: A write device byte plus word address, followed by a repeated start and a read device byte, returns the byte at that word address.
- R8: In a read, each acknowledge from the master makes the block send the byte at the next address. The address advances over all 11 bits, so address 2047 is followed by address 0. A negative acknowledge from the master ends the transfer.
- R9: While the reset-hold input is high, no device byte is acknowledged.
- R10: The data pull-down is inactive after reset. It changes to active only while the synchronised bus clock is low, and it is never active during the high phase of bits that the master owns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wprot_i | input | 1 | Write protect, high blocks data bytes |
| inhibit_i | input | 1 | Reset-hold, high blocks device-byte acknowledge |
| sda_drive_o | output | 1 | High pulls the data line low |

## Verification
Two things can land in the same transaction window: the busy interval that a commit starts, and the decode of a new device byte. The bench provokes this by sending a device byte straight after the committing stop. It expects no acknowledge while its own model still counts the busy window, and an acknowledge once the window has passed. A second overlap is the page-offset wrap together with a data byte: a write that starts two bytes before the end of a page and runs past sixteen bytes makes the wrapped offset replace data already buffered. The bench judges this by reading the whole page back against its model.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wprot_i,
  input  logic inhibit_i,
  output logic sda_drive_o
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int HIW = AW - 8;
  localparam int BW  = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_DEV = 3'd1, S_WADR = 3'd2,
    S_WDAT = 3'd3, S_RDAT = 3'd4, S_WAIT = 3'd5
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire  scl_s = scl_sy[1];
  wire  sda_s = sda_sy[1];

  st_t st;
  logic [3:0] cnt;
  logic ack_slot, mack;
  logic [7:0] sh, tx;
  logic [AW-1:0] ptr;
  logic [HIW-1:0] hi;
  logic [AW-PW-1:0] pbase;
  logic [PW-1:0] woff;
  logic [PAGE_BYTES-1:0] pvalid;
  logic [BW-1:0] busy;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [7:0] mem  [MEM_BYTES];

  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rx_st   = (st == S_DEV) | (st == S_WADR) | (st == S_WDAT);
  wire done_rx = fall & ~ack_slot & rx_st & (cnt == 4'd8);
  wire dev_hit = (sh[7:4] == 4'b1010) & (busy == '0) & ~inhibit_i;
  wire data_ok = done_rx & (st == S_WDAT) & ~wprot_i;
  wire commit  = stop_c & (|pvalid);

  always_ff @(posedge clk) begin
    if (data_ok) pbuf[woff] <= sh;
    for (int i = 0; i < PAGE_BYTES; i++)
      if (commit && pvalid[i]) mem[{pbase, PW'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; ack_slot <= 1'b0; mack <= 1'b0;
      sh <= '0; tx <= '0; ptr <= '0; hi <= '0; pbase <= '0; woff <= '0;
      pvalid <= '0; busy <= '0; sda_drive_o <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (commit) busy <= BW'(BUSY_CYCLES);
      else if (busy != '0) busy <= busy - 1'b1;

      if (start_c) begin
        st <= S_DEV; cnt <= '0; ack_slot <= 1'b0; sda_drive_o <= 1'b0; pvalid <= '0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; ack_slot <= 1'b0; sda_drive_o <= 1'b0; pvalid <= '0;
      end else if (rise && !ack_slot && rx_st && cnt != 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end else if (done_rx) begin
        cnt <= '0;
        case (st)
          S_DEV: begin
            if (dev_hit) begin
              ack_slot <= 1'b1; sda_drive_o <= 1'b1; mack <= 1'b1;
              hi <= sh[HIW:1];
              st <= sh[0] ? S_RDAT : S_WADR;
            end else st <= S_WAIT;
          end
          S_WADR: begin
            ack_slot <= 1'b1; sda_drive_o <= 1'b1;
            ptr   <= {hi, sh};
            pbase <= {hi, sh[7:PW]};
            woff  <= sh[PW-1:0];
            st    <= S_WDAT;
          end
          default: begin
            if (wprot_i) st <= S_WAIT;
            else begin
              ack_slot <= 1'b1; sda_drive_o <= 1'b1;
              pvalid[woff] <= 1'b1;
              woff <= woff + 1'b1;
              ptr  <= {pbase, woff + 1'b1};
            end
          end
        endcase
      end else if (fall && ack_slot && st != S_RDAT) begin
        ack_slot <= 1'b0; sda_drive_o <= 1'b0;
      end else if (st == S_RDAT) begin
        if (rise && ack_slot) mack <= ~sda_s;
        else if (fall && ack_slot) begin
          ack_slot <= 1'b0;
          if (mack) begin
            tx <= mem[ptr]; sda_drive_o <= ~mem[ptr][7];
            ptr <= ptr + 1'b1; cnt <= 4'd1;
          end else begin
            sda_drive_o <= 1'b0; st <= S_WAIT;
          end
        end else if (fall) begin
          if (cnt != 4'd8) begin
            sda_drive_o <= ~tx[6]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 1'b1;
          end else begin
            sda_drive_o <= 1'b0; ack_slot <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int BW = 4,
  parameter int PB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_drive_o,
  input logic          wprot_i,
  input logic          inhibit_i,
  input logic [2:0]    st,
  input logic [BW-1:0] busy,
  input logic [PB-1:0] pvalid
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_DEV  = 3'd1;
  localparam logic [2:0] C_WAIT = 3'd5;

  // R10
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_o) |-> !scl_s);

  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE || st == C_WAIT) |-> !sda_drive_o);

  // R4 R9
  dev_ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_o) && $past(st) == C_DEV) |-> ($past(busy) == '0 && !$past(inhibit_i)));

  // R5
  no_protected_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wprot_i |=> ((pvalid & ~$past(pvalid)) == '0));

  // R4
  busy_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0) |=> (busy < $past(busy)));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.BW(BW), .PB(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drive_o(sda_drive_o),
  .wprot_i(wprot_i), .inhibit_i(inhibit_i), .st(st), .busy(busy), .pvalid(pvalid)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam int BUSY  = 400;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0, inh = 1'b0;
  wire  drv;
  wire  sda_bus = m_sda & ~drv;

  int errors = 0, checks = 0, cyc = 0, busy_until = 0, ref_ptr = 0;
  bit may_drive = 1'b0, done = 1'b0;
  logic [7:0] ref_mem [int];

  always #(CLK_P/2) clk = ~clk;

  i2c_mem_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .wprot_i(wp), .inhibit_i(inh), .sda_drive_o(drv)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // R10: no pull-down during master-owned high phases
  always @(negedge clk) if (rst_n && m_scl && !may_drive && !done) begin
    checks++;
    if (drv) begin
      errors++;
      $display("FAIL R10 pull-down in master phase actual=%0b expected=0", drv);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; may_drive = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    ack = !sda_bus;
    m_scl = 1'b0; wt(Q); may_drive = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    may_drive = 1'b1; m_sda = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(Q); m_scl = 1'b1; wt(Q); b = {b[6:0], sda_bus}; m_scl = 1'b0;
    end
    wt(Q); m_sda = give_ack ? 1'b0 : 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
    m_sda = 1'b1; may_drive = 1'b0;
  endtask

  function automatic bit exp_dev_ack(input logic [7:0] dev);
    return (dev[7:4] == 4'hA) && !inh && (cyc >= busy_until);
  endfunction

  task automatic dev_only(input logic [7:0] dev, input string tag);
    bit ack;
    bus_start(); send_byte(dev, ack); chk(tag, ack, exp_dev_ack(dev)); bus_stop();
  endtask

  task automatic wr_bytes(input int a, input logic [7:0] d[$], input string tag);
    bit ack, prog;
    logic [10:0] aa;
    logic [7:0] dev;
    int base, off;
    aa = 11'(a); dev = {4'hA, aa[10:8], 1'b0}; prog = 1'b0;
    bus_start(); send_byte(dev, ack); chk("R1 write device byte ack", ack, exp_dev_ack(dev));
    send_byte(aa[7:0], ack); chk("R2 word address ack", ack, 1);
    ref_ptr = a; base = a & ~15; off = a & 15;
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(tag, ack, wp ? 0 : 1);
      if (wp) break;
      ref_mem[base + off] = d[i]; off = (off + 1) % 16; ref_ptr = base + off; prog = 1'b1;
    end
    bus_stop();
    if (prog) busy_until = cyc + BUSY;
  endtask

  task automatic rd_seq(input int a, input int n, input string tag);
    bit ack;
    logic [7:0] b, dev;
    logic [10:0] aa;
    if (a >= 0) begin
      aa = 11'(a); dev = {4'hA, aa[10:8], 1'b0};
      bus_start(); send_byte(dev, ack); chk("R7 dummy write ack", ack, exp_dev_ack(dev));
      send_byte(aa[7:0], ack); chk("R7 read word address ack", ack, 1);
      ref_ptr = a;
    end
    dev = 8'hA1;
    bus_start(); send_byte(dev, ack); chk("R1 read device byte ack", ack, exp_dev_ack(dev));
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      if (ref_mem.exists(ref_ptr)) chk(tag, b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 2048;
    end
    bus_stop();
  endtask

  initial begin
    logic [7:0] pg[$];
    wt(5); rst_n = 1'b1; wt(5);
    chk("R10 pull-down off after reset", drv, 0);

    dev_only(8'hB0, "R1 foreign device nibble refused");

    wr_bytes(11'h123, '{8'h5A}, "R2 byte write data ack");
    dev_only(8'hA2, "R4 poll refused while busy");
    wt(BUSY + 50);
    dev_only(8'hA2, "R4 poll accepted after busy");
    rd_seq(11'h123, 1, "R7 random read data");

    pg = {};
    for (int i = 0; i < 18; i++) pg.push_back(8'(8'h30 + i));
    wr_bytes(11'h24E, pg, "R3 page write data ack");
    wt(BUSY + 50);
    rd_seq(11'h240, 16, "R3 page wrap contents");
    wr_bytes(11'h244, '{8'hE7, 8'hE8}, "R3 partial page data ack");
    wt(BUSY + 50);
    rd_seq(11'h240, 16, "R3 unreceived bytes kept");

    wr_bytes(11'h250, '{8'hC3, 8'hC4}, "R2 two-byte write ack");
    wt(BUSY + 50);
    rd_seq(11'h250, 1, "R7 random read first byte");
    rd_seq(-1, 1, "R6 current address read");

    wr_bytes(11'h7FF, '{8'hE1}, "R2 top byte write ack");
    wt(BUSY + 50);
    wr_bytes(11'h000, '{8'h0E}, "R2 bottom byte write ack");
    wt(BUSY + 50);
    rd_seq(11'h7FF, 2, "R8 sequential read wraps to zero");
    rd_seq(11'h123, 1, "R8 read after negative ack ended transfer");

    wr_bytes(11'h300, '{8'h11}, "R2 write before protect ack");
    wt(BUSY + 50);
    wp = 1'b1;
    wr_bytes(11'h300, '{8'h99}, "R5 protected data refused");
    wp = 1'b0;
    wt(BUSY + 50);
    rd_seq(11'h300, 1, "R5 protected location unchanged");

    inh = 1'b1;
    dev_only(8'hA0, "R9 device byte refused under reset-hold");
    inh = 1'b0;
    dev_only(8'hA0, "R9 device byte accepted after reset-hold");

    wt(20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule